// File: doc/BRIEF.md
# Link Rate and Lane Fallback Selector

This block chooses the sequence of link configurations that a serial display link trainer tries, one after another. Each configuration is a pair of a per-lane bandwidth code and a lane count. The block walks a fixed candidate list ordered from the highest total rate to the lowest. It passes over every candidate that either the attached sink or the local encoder cannot carry. The training sequencer that uses it pulses a start strobe to begin a new selection, and a next strobe each time a training attempt at the offered configuration fails.

On start, the block takes a snapshot of the sink capabilities and clamps them to the encoder limits. It also records whether the alternate training pattern (pattern 3, together with post-cursor2 drive) may be used. When a nonzero required payload rate is given, the block first scales it for 8b/10b coding overhead. It then moves its starting point down the list, so that the first offer is the lowest-rate candidate that still meets the demand. Candidates are then examined one per clock cycle. The block raises a valid flag when it finds one that fits, and an exhausted flag when the list runs out.

Top module: `lnk_cfg_selector`

## Requirements
- R1: After reset, cfg_valid_o, exhausted_o, bw_code_o, lanes_o and link_kbps_o are all 0 until the first start.
- R2: On start, the effective lane limit is min(sink_lane_field_i[4:0], enc_max_lanes_i) and the effective code limit is min(sink_rate_code_i, enc_max_code_i); a candidate is offered only if its lane count and its code are both within those limits.
- R3: Candidates are examined in this fixed order as (code, lanes): (0x14,4), (0x0a,4), (0x14,2), (0x06,4), (0x0a,2), (0x14,1), (0x06,2), (0x0a,1), (0x06,1). A candidate's total rate in kB/s is code × 27000 × lanes.
- R4: With req_kbps_i = 0 at start, the first offer is the first fitting candidate counted from the head of the list.
- R5: With req_kbps_i ≠ 0 at start, the demand is D = (req_kbps_i / 8) × 10 (integer division). The start index moves forward while the following candidate's total rate is ≥ D, stopping at the last candidate. The fitting search begins at that index.
- R6: A next pulse while an offer is valid drops cfg_valid_o on the following cycle, and the search resumes at the candidate after the current one.
- R7: When no fitting candidate remains, exhausted_o is set. bw_code_o and lanes_o keep the last offer of this selection, or 0 if there was none. Further next pulses change nothing until the next start.
- R8: link_kbps_o equals bw_code_o × 27000.
- R9: Each table index costs one cycle. After start, an offer at index j appears j+1 cycles later, plus one cycle when a demand was given. Exhaustion appears after 9 cycles, or 10 with a demand. After a next at index i, an offer at j appears after j−i cycles, and exhaustion after 8−i cycles.
- R10: pattern3_en_o and post_cursor2_en_o both equal sink_p3_i AND enc_p3_i as sampled at start.
- R11: Changes on the capability, demand and pattern inputs after start have no effect until the next start.
- R12: start_i takes priority over next_i; cfg_valid_o and exhausted_o are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a new selection, sampling all capability inputs |
| next_i | input | 1 | Reject the current offer and search onward |
| sink_rate_code_i | input | 8 | Sink maximum bandwidth code |
| sink_lane_field_i | input | 8 | Sink lane capability field, lane count in bits 4:0 |
| enc_max_lanes_i | input | 5 | Encoder lane limit |
| enc_max_code_i | input | 8 | Encoder bandwidth code limit |
| sink_p3_i | input | 1 | Sink supports training pattern 3 |
| enc_p3_i | input | 1 | Encoder supports training pattern 3 |
| req_kbps_i | input | 32 | Required payload rate in kB/s, 0 for none |
| bw_code_o | output | 8 | Offered bandwidth code |
| lanes_o | output | 3 | Offered lane count |
| link_kbps_o | output | 32 | Per-lane link bandwidth in kB/s |
| cfg_valid_o | output | 1 | An offer is present |
| exhausted_o | output | 1 | No fitting candidate remains |
| pattern3_en_o | output | 1 | Use training pattern 3 |
| post_cursor2_en_o | output | 1 | Use post-cursor2 drive |

## Verification
The hold properties assume that no start arrives in the cycle they examine. The stimulus therefore issues start only between selections, and each start or next strobe is held for a single cycle. The properties make no assumption about when next arrives relative to the search. Even so, the bench only pulses next while an offer is valid or after exhaustion. The demand values are chosen to fall at and between candidate rates, and they stay well inside 32 bits, so the 10/8 scaling never overflows.

// File: rtl/lnk_sel_pkg.sv
package lnk_sel_pkg;
    localparam int CODE_W       = 8;
    localparam int LANE_W       = 5;
    localparam int LANE_FIELD_W = 8;
    localparam int LANE_OUT_W   = 3;
    localparam int RATE_W       = 32;
    localparam int NUM_ENTRIES  = 9;
    localparam int IDX_W        = $clog2(NUM_ENTRIES);
    localparam int UNIT_KBPS    = 27000;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);

    typedef enum logic [2:0] {S_IDLE, S_SCAN, S_SEEK, S_OFFER, S_DONE} sel_state_e;

    typedef struct packed {
        sel_state_e              st;
        logic [IDX_W-1:0]        idx;
        logic [LANE_W-1:0]       eff_lanes;
        logic [CODE_W-1:0]       eff_code;
        logic [RATE_W-1:0]       demand;
        logic                    p3;
        logic [CODE_W-1:0]       out_code;
        logic [LANE_OUT_W-1:0]   out_lanes;
    } sel_regs_t;

    // R3: candidate list, highest total rate first
    function automatic logic [CODE_W-1:0] entry_code(input logic [IDX_W-1:0] i);
        case (i)
            0, 2, 5: return CODE_W'(8'h14);
            1, 4, 7: return CODE_W'(8'h0a);
            3, 6, 8: return CODE_W'(8'h06);
            default: return '0;
        endcase
    endfunction

    function automatic logic [LANE_OUT_W-1:0] entry_lanes(input logic [IDX_W-1:0] i);
        case (i)
            0, 1, 3: return LANE_OUT_W'(4);
            2, 4, 6: return LANE_OUT_W'(2);
            5, 7, 8: return LANE_OUT_W'(1);
            default: return '0;
        endcase
    endfunction

    function automatic logic [RATE_W-1:0] entry_kbps(input logic [IDX_W-1:0] i);
        return RATE_W'(entry_code(i)) * RATE_W'(UNIT_KBPS) * RATE_W'(entry_lanes(i));
    endfunction
endpackage

// File: rtl/lnk_cap_clamp.sv
module lnk_cap_clamp
    import lnk_sel_pkg::*;
(
    input  logic [CODE_W-1:0]       sink_code_i,
    input  logic [LANE_FIELD_W-1:0] sink_lane_field_i,
    input  logic [LANE_W-1:0]       enc_lanes_i,
    input  logic [CODE_W-1:0]       enc_code_i,
    output logic [LANE_W-1:0]       eff_lanes_o,
    output logic [CODE_W-1:0]       eff_code_o
);
    logic [LANE_W-1:0] sink_lanes;

    always_comb begin
        sink_lanes  = sink_lane_field_i[LANE_W-1:0];
        eff_lanes_o = (sink_lanes > enc_lanes_i) ? enc_lanes_i : sink_lanes;
        eff_code_o  = (sink_code_i > enc_code_i) ? enc_code_i : sink_code_i;
    end
endmodule

// File: rtl/lnk_entry_fit.sv
module lnk_entry_fit
    import lnk_sel_pkg::*;
(
    input  logic [IDX_W-1:0]      idx_i,
    input  logic [LANE_W-1:0]     eff_lanes_i,
    input  logic [CODE_W-1:0]     eff_code_i,
    output logic                  fits_o,
    output logic [CODE_W-1:0]     code_o,
    output logic [LANE_OUT_W-1:0] lanes_o
);
    always_comb begin
        code_o  = entry_code(idx_i);
        lanes_o = entry_lanes(idx_i);
        fits_o  = (LANE_W'(lanes_o) <= eff_lanes_i) && (code_o <= eff_code_i);
    end
endmodule

// File: rtl/lnk_demand_scan.sv
module lnk_demand_scan
    import lnk_sel_pkg::*;
(
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [RATE_W-1:0] demand_i,
    output logic              advance_o
);
    localparam int SW = RATE_W + 2;
    logic [SW-1:0] scaled;
    logic [SW-1:0] follow_rate;

    always_comb begin
        scaled      = SW'(demand_i >> 3) * SW'(10);
        follow_rate = '0;
        if (idx_i < LAST_IDX) follow_rate = SW'(entry_kbps(idx_i + 1'b1));
        advance_o   = (idx_i < LAST_IDX) && (follow_rate >= scaled);
    end
endmodule

// File: rtl/lnk_cfg_selector.sv
module lnk_cfg_selector
    import lnk_sel_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic                    next_i,
    input  logic [CODE_W-1:0]       sink_rate_code_i,
    input  logic [LANE_FIELD_W-1:0] sink_lane_field_i,
    input  logic [LANE_W-1:0]       enc_max_lanes_i,
    input  logic [CODE_W-1:0]       enc_max_code_i,
    input  logic                    sink_p3_i,
    input  logic                    enc_p3_i,
    input  logic [RATE_W-1:0]       req_kbps_i,
    output logic [CODE_W-1:0]       bw_code_o,
    output logic [LANE_OUT_W-1:0]   lanes_o,
    output logic [RATE_W-1:0]       link_kbps_o,
    output logic                    cfg_valid_o,
    output logic                    exhausted_o,
    output logic                    pattern3_en_o,
    output logic                    post_cursor2_en_o
);
    sel_regs_t st_d, st_q;

    logic [LANE_W-1:0]     clamp_lanes;
    logic [CODE_W-1:0]     clamp_code;
    logic                  cand_fits;
    logic [CODE_W-1:0]     cand_code;
    logic [LANE_OUT_W-1:0] cand_lanes;
    logic                  scan_adv;

    lnk_cap_clamp i_clamp (
        .sink_code_i       (sink_rate_code_i),
        .sink_lane_field_i (sink_lane_field_i),
        .enc_lanes_i       (enc_max_lanes_i),
        .enc_code_i        (enc_max_code_i),
        .eff_lanes_o       (clamp_lanes),
        .eff_code_o        (clamp_code)
    );

    lnk_entry_fit i_fit (
        .idx_i       (st_q.idx),
        .eff_lanes_i (st_q.eff_lanes),
        .eff_code_i  (st_q.eff_code),
        .fits_o      (cand_fits),
        .code_o      (cand_code),
        .lanes_o     (cand_lanes)
    );

    lnk_demand_scan i_scan (
        .idx_i     (st_q.idx),
        .demand_i  (st_q.demand),
        .advance_o (scan_adv)
    );

    always_comb begin
        st_d = st_q;
        case (st_q.st)
            S_SCAN: begin
                if (scan_adv) st_d.idx = st_q.idx + 1'b1;
                else          st_d.st  = S_SEEK;
            end
            S_SEEK: begin
                if (cand_fits) begin
                    st_d.out_code  = cand_code;
                    st_d.out_lanes = cand_lanes;
                    st_d.st        = S_OFFER;
                end else if (st_q.idx == LAST_IDX) begin
                    st_d.st = S_DONE;
                end else begin
                    st_d.idx = st_q.idx + 1'b1;
                end
            end
            S_OFFER: begin
                if (next_i) begin
                    if (st_q.idx == LAST_IDX) begin
                        st_d.st = S_DONE;
                    end else begin
                        st_d.idx = st_q.idx + 1'b1;
                        st_d.st  = S_SEEK;
                    end
                end
            end
            default: ;
        endcase
        if (start_i) begin
            st_d.eff_lanes = clamp_lanes;
            st_d.eff_code  = clamp_code;
            st_d.demand    = req_kbps_i;
            st_d.p3        = sink_p3_i & enc_p3_i;
            st_d.idx       = '0;
            st_d.out_code  = '0;
            st_d.out_lanes = '0;
            st_d.st        = (req_kbps_i != '0) ? S_SCAN : S_SEEK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{st: S_IDLE, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign bw_code_o         = st_q.out_code;
    assign lanes_o           = st_q.out_lanes;
    assign link_kbps_o       = RATE_W'(st_q.out_code) * RATE_W'(UNIT_KBPS);
    assign cfg_valid_o       = (st_q.st == S_OFFER);
    assign exhausted_o       = (st_q.st == S_DONE);
    assign pattern3_en_o     = st_q.p3;
    assign post_cursor2_en_o = st_q.p3;

    // R2
    fit_caps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid_o |-> (LANE_W'(lanes_o) <= st_q.eff_lanes) && (bw_code_o <= st_q.eff_code));

    // R3
    lane_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid_o |-> (lanes_o == 3'd1 || lanes_o == 3'd2 || lanes_o == 3'd4));

    // R6
    offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid_o && !next_i && !start_i |=> cfg_valid_o && $stable(bw_code_o) && $stable(lanes_o));

    // R6
    next_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid_o && next_i && !start_i |=> !cfg_valid_o);

    // R7
    exhaust_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exhausted_o && !start_i |=> exhausted_o && $stable(bw_code_o) && $stable(lanes_o));

    // R12
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_valid_o && exhausted_o));

    // R4
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !cfg_valid_o && !exhausted_o && bw_code_o == '0);
endmodule

// File: tb/test_lnk_cfg_selector.sv
module test_lnk_cfg_selector;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n, start_i, next_i, sink_p3_i, enc_p3_i;
    logic [7:0]  sink_rate_code_i, sink_lane_field_i, enc_max_code_i;
    logic [4:0]  enc_max_lanes_i;
    logic [31:0] req_kbps_i;
    logic [7:0]  bw_code_o;
    logic [2:0]  lanes_o;
    logic [31:0] link_kbps_o;
    logic        cfg_valid_o, exhausted_o, pattern3_en_o, post_cursor2_en_o;

    int checks = 0;
    int errors = 0;

    lnk_cfg_selector i_lnk_cfg_selector (.*);

    function automatic int tb_code(int i);
        int c[9] = '{8'h14, 8'h0a, 8'h14, 8'h06, 8'h0a, 8'h14, 8'h06, 8'h0a, 8'h06};
        return c[i];
    endfunction
    function automatic int tb_lanes(int i);
        int l[9] = '{4, 4, 2, 4, 2, 1, 2, 1, 1};
        return l[i];
    endfunction
    function automatic longint tb_rate(int i);
        return longint'(tb_code(i)) * 27000 * tb_lanes(i);
    endfunction

    task automatic chk(bit ok, string tag, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic run_cfg(int sl, int sr, int el, int er, int req, bit sp, bit ep);
        int effl, effr, s, pos, j, n, last_code, last_lanes, prev;
        bit first;
        @(negedge clk);
        sink_lane_field_i = 8'(sl); sink_rate_code_i = 8'(sr);
        enc_max_lanes_i = 5'(el); enc_max_code_i = 8'(er);
        req_kbps_i = 32'(req); sink_p3_i = sp; enc_p3_i = ep;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        // R11: scramble every sampled input after start
        sink_lane_field_i = 8'h1f; sink_rate_code_i = 8'hff;
        enc_max_lanes_i = 5'h1f; enc_max_code_i = 8'hff;
        req_kbps_i = 32'd0; sink_p3_i = ~sp; enc_p3_i = ~ep;
        effl = ((sl & 31) > el) ? el : (sl & 31);
        effr = (sr > er) ? er : sr;
        s = 0;
        if (req != 0)
            while (s < 8 && tb_rate(s + 1) >= longint'(req / 8) * 10) s++;
        pos = s; prev = 0; first = 1'b1; last_code = 0; last_lanes = 0;
        forever begin
            j = pos;
            while (j < 9 && (tb_lanes(j) > effl || tb_code(j) > effr)) j++;
            n = 0;
            while (!(cfg_valid_o || exhausted_o) && n < 40) begin
                @(negedge clk); n++;
            end
            if (j < 9) begin
                chk(cfg_valid_o && !exhausted_o, "R2", "offer present", cfg_valid_o, 1);
                chk(bw_code_o == 8'(tb_code(j)), "R3", "code (R5 R11)", bw_code_o, tb_code(j));
                chk(lanes_o == 3'(tb_lanes(j)), "R3", "lanes (R4 R5)", lanes_o, tb_lanes(j));
                chk(link_kbps_o == 32'(tb_code(j) * 27000), "R8", "link kbps", link_kbps_o, tb_code(j) * 27000);
                chk(n == (first ? j + 1 + (req != 0 ? 1 : 0) : j - prev), "R9", "offer latency", n,
                    first ? j + 1 + (req != 0 ? 1 : 0) : j - prev);
            end else begin
                chk(exhausted_o && !cfg_valid_o, "R7", "exhausted", exhausted_o, 1);
                chk(n == (first ? 9 + (req != 0 ? 1 : 0) : 8 - prev), "R9", "exhaust latency", n,
                    first ? 9 + (req != 0 ? 1 : 0) : 8 - prev);
            end
            if (first) begin
                chk(pattern3_en_o == (sp & ep), "R10", "pattern3", pattern3_en_o, sp & ep);
                chk(post_cursor2_en_o == (sp & ep), "R10", "post cursor2", post_cursor2_en_o, sp & ep);
                first = 1'b0;
            end
            if (j >= 9) begin
                chk(bw_code_o == 8'(last_code), "R7", "held code", bw_code_o, last_code);
                next_i = 1'b1;
                @(negedge clk);
                next_i = 1'b0;
                repeat (3) @(negedge clk);
                chk(exhausted_o && bw_code_o == 8'(last_code) && lanes_o == 3'(last_lanes),
                    "R7", "next ignored when exhausted", bw_code_o, last_code);
                break;
            end
            last_code = tb_code(j); last_lanes = tb_lanes(j);
            next_i = 1'b1;
            @(negedge clk);
            next_i = 1'b0;
            chk(!cfg_valid_o, "R6", "valid drops after next", cfg_valid_o, 0);
            prev = j; pos = j + 1;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int sls[6] = '{1, 2, 3, 4, 8, 8'h84};
        int srs[5] = '{8'h05, 8'h06, 8'h0a, 8'h14, 8'h1e};
        int els[3] = '{1, 2, 4};
        int ers[3] = '{8'h06, 8'h0a, 8'h14};
        int rqs[4] = '{0, 200000, 500000, 1000000};
        int cnt = 0;
        rst_n = 1'b0; start_i = 1'b0; next_i = 1'b0;
        sink_rate_code_i = '0; sink_lane_field_i = '0; enc_max_lanes_i = '0;
        enc_max_code_i = '0; req_kbps_i = '0; sink_p3_i = 1'b0; enc_p3_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1
        chk(!cfg_valid_o && !exhausted_o, "R1", "flags after reset", cfg_valid_o | exhausted_o, 0);
        chk(bw_code_o == 0 && lanes_o == 0 && link_kbps_o == 0, "R1", "outputs after reset", bw_code_o, 0);
        // R12: start together with next still restarts
        @(negedge clk);
        sink_lane_field_i = 8'd4; sink_rate_code_i = 8'h14; enc_max_lanes_i = 5'd4;
        enc_max_code_i = 8'h14; start_i = 1'b1; next_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; next_i = 1'b0;
        chk(!cfg_valid_o && !exhausted_o, "R12", "start wins over next", cfg_valid_o, 0);
        @(negedge clk);
        chk(cfg_valid_o && bw_code_o == 8'h14 && lanes_o == 3'd4, "R12", "first entry after start", bw_code_o, 8'h14);
        foreach (sls[a]) foreach (srs[b]) foreach (els[c]) foreach (ers[d]) foreach (rqs[e]) begin
            run_cfg(sls[a], srs[b], els[c], ers[d], rqs[e], cnt[0], cnt[1] | cnt[2]);
            cnt++;
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule